// File: doc/BRIEF.md
# Firmware Upgrade Control State Machine

This block is the device-side control sequencer for the USB firmware-upgrade class. A control-transfer decoder upstream hands it one class request per cycle: detach, download with a block length, get-status, clear-status or abort. Alongside these it receives a bus-reset indication and completion or failure flags from the flash programming agent. The block keeps the class state and presents its numeric code for status replies. It issues one-cycle start pulses that launch block programming and image manifestation in the memory back end.

Get-status polls drive progress. A downloaded block waits in a sync state until the host polls. The poll then reports busy or idle, depending on whether the programming agent has finished. A zero-length download closes the image, and the next poll starts manifestation. An oversize block, a zero-length first block, or any request that is not legal in the current state moves the machine into the error state. The error state records a cause code, and only a clear-status request leaves it. A parameter selects whether the device may return to the idle state after manifestation or must wait for a bus reset.

Top module: `fwup_ctrl`

## Requirements
- R1: After reset, state_code is 0 (application idle), err_code is 0, and prog_start, manif_start and reply_valid are low. State codes: 0 app idle, 1 app detach, 2 idle, 3 download sync, 4 download busy, 5 download idle, 6 manifest sync, 7 manifest, 8 manifest wait-reset, 10 error. No other code ever appears.
- R2: Request kinds are encoded as 0 detach, 1 download, 2 get-status, 3 clear-status and 4 abort; 5 to 7 are illegal. A detach in state 0 moves to state 1. A bus reset in state 1 moves to state 2. A bus reset in any state other than 1 or 8 is ignored.
- R3: A download whose length is 1 to MAX_BLOCK, in state 2 or 5, moves to state 3. prog_start is high for the single cycle in which state 3 is first shown.
- R4: A get-status in state 3 moves to state 5 if the programming agent has reported done since the last prog_start, including in the same cycle, and otherwise to state 4. State 4 moves to state 3 once done has been reported.
- R5: A download of length 0 in state 5 moves to state 6. A get-status in state 6 moves to state 7, with manif_start high for that one cycle.
- R6: In state 7, manif_done moves to state 2 when MANIF_TOLERANT is 1 and to state 8 when it is 0. A bus reset in state 8 moves to state 0.
- R7: Error codes are 0 none, 1 bad length, 2 illegal request, 3 programming failure and 4 manifestation failure. Each of the following moves to state 10 and sets err_code: a download longer than MAX_BLOCK, or of length 0 in state 2, gives code 1. A request not legal in the current state gives code 2; get-status is legal everywhere except states 4 and 7. prog_err in state 3 or 4 gives code 3. manif_err in state 7 gives code 4.
- R8: In state 10, clear-status moves to state 2 and sets err_code to 0. Every other request leaves both the state and err_code unchanged.
- R9: Every processed get-status is followed one cycle later by reply_valid high for a single cycle. In that cycle, reply_state and reply_err equal state_code and err_code as they stand after the transition that the request caused.
- R10: An abort in state 2 or 5 moves to state 2 with err_code unchanged. An abort in any other state except 10 is illegal and gives code 2.
- R11: A bus reset that acts in state 1 or 8 drops a request given in the same cycle, and so does prog_err in state 3 or 4 or manif_err in state 7. A request otherwise takes priority over the state 4 and state 7 completions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A decoded class request is present this cycle |
| req_kind | input | 3 | Request kind code |
| req_len | input | LEN_W | Download block length in bytes |
| bus_reset | input | 1 | USB bus reset seen |
| prog_done | input | 1 | Programming agent finished the current block |
| prog_err | input | 1 | Programming agent failed |
| manif_done | input | 1 | Manifestation finished |
| manif_err | input | 1 | Manifestation failed |
| state_code | output | 4 | Current class state code |
| err_code | output | 4 | Latched error cause |
| prog_start | output | 1 | One-cycle pulse to start block programming |
| manif_start | output | 1 | One-cycle pulse to start manifestation |
| reply_valid | output | 1 | A status reply is ready |
| reply_state | output | 4 | State code carried by the reply |
| reply_err | output | 4 | Error code carried by the reply |

## Verification
The assertions assume that each request is a one-cycle pulse sampled on a rising edge. They also assume that the completion and failure flags are single-cycle pulses, and that every input is stable around the edge. The stimulus drives each request, bus reset and agent flag as a one-cycle pulse, launched shortly after a rising edge. It also combines them deliberately: a bus reset together with a request, a poll in the same cycle as done, and requests in the busy, manifest and error states. Under these conditions the transition relations stated in the checker hold on every edge.

// File: rtl/fwup_pkg.sv
package fwup_pkg;

  typedef enum logic [3:0] {
    ST_APP_IDLE   = 4'd0,
    ST_APP_DETACH = 4'd1,
    ST_IDLE       = 4'd2,
    ST_DL_SYNC    = 4'd3,
    ST_DL_BUSY    = 4'd4,
    ST_DL_IDLE    = 4'd5,
    ST_MF_SYNC    = 4'd6,
    ST_MANIFEST   = 4'd7,
    ST_MF_WAITRST = 4'd8,
    ST_ERROR      = 4'd10
  } fw_state_e;

  typedef enum logic [2:0] {
    RQ_DETACH = 3'd0,
    RQ_DNLOAD = 3'd1,
    RQ_STATUS = 3'd2,
    RQ_CLEAR  = 3'd3,
    RQ_ABORT  = 3'd4
  } fw_req_e;

  localparam logic [3:0] ERR_NONE  = 4'd0;
  localparam logic [3:0] ERR_LEN   = 4'd1;
  localparam logic [3:0] ERR_STALL = 4'd2;
  localparam logic [3:0] ERR_PROG  = 4'd3;
  localparam logic [3:0] ERR_MANIF = 4'd4;

  // Block length above the allowed maximum
  function automatic logic len_too_long(input int unsigned len, input int unsigned max_len);
    return len > max_len;
  endfunction

  // Block length of zero (end-of-image marker)
  function automatic logic len_is_zero(input int unsigned len);
    return len == 0;
  endfunction

endpackage

// File: rtl/fwup_len_check.sv
module fwup_len_check #(
  parameter int LEN_W     = 16,
  parameter int MAX_BLOCK = 2048
) (
  input  logic [LEN_W-1:0] len,
  output logic             len_zero,
  output logic             len_over
);
  import fwup_pkg::*;
  localparam int unsigned MAX_U = MAX_BLOCK;

  always_comb begin
    len_zero = len_is_zero(32'(len));
    len_over = len_too_long(32'(len), MAX_U);
  end
endmodule

// File: rtl/fwup_blk_track.sv
module fwup_blk_track (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic prog_done,
  output logic done_any
);
  logic blk_done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        blk_done_q <= 1'b0;
    else if (clr)      blk_done_q <= 1'b0;
    else if (prog_done) blk_done_q <= 1'b1;
  end

  assign done_any = blk_done_q | prog_done;
endmodule

// File: rtl/fwup_next.sv
module fwup_next #(
  parameter bit MANIF_TOLERANT = 1'b0
) (
  input  fwup_pkg::fw_state_e cur,
  input  logic [3:0]          err,
  input  logic                req_valid,
  input  logic [2:0]          req_kind,
  input  logic                len_zero,
  input  logic                len_over,
  input  logic                bus_reset,
  input  logic                done_any,
  input  logic                prog_err,
  input  logic                manif_done,
  input  logic                manif_err,
  output fwup_pkg::fw_state_e nxt,
  output logic [3:0]          nxt_err,
  output logic                fire_prog,
  output logic                fire_manif,
  output logic                fire_reply
);
  import fwup_pkg::*;

  logic is_status, is_dnload;

  always_comb begin
    is_status = (req_kind == RQ_STATUS);
    is_dnload = (req_kind == RQ_DNLOAD);
    nxt        = cur;
    nxt_err    = err;
    fire_prog  = 1'b0;
    fire_manif = 1'b0;
    fire_reply = 1'b0;

    if (bus_reset && cur == ST_APP_DETACH) begin
      nxt = ST_IDLE;
    end else if (bus_reset && cur == ST_MF_WAITRST) begin
      nxt = ST_APP_IDLE;
    end else if (prog_err && (cur == ST_DL_SYNC || cur == ST_DL_BUSY)) begin
      nxt = ST_ERROR; nxt_err = ERR_PROG;
    end else if (manif_err && cur == ST_MANIFEST) begin
      nxt = ST_ERROR; nxt_err = ERR_MANIF;
    end else if (req_valid) begin
      fire_reply = is_status;
      // Default for any request not listed as legal below
      if (cur != ST_ERROR) begin
        nxt = ST_ERROR; nxt_err = ERR_STALL;
      end
      unique case (cur)
        ST_APP_IDLE: begin
          if (req_kind == RQ_DETACH) begin nxt = ST_APP_DETACH; nxt_err = err; end
          else if (is_status)        begin nxt = cur; nxt_err = err; end
        end
        ST_APP_DETACH, ST_MF_WAITRST: begin
          if (is_status) begin nxt = cur; nxt_err = err; end
        end
        ST_IDLE, ST_DL_IDLE: begin
          if (is_dnload) begin
            if (len_over || (len_zero && cur == ST_IDLE)) begin
              nxt_err = ERR_LEN;
            end else if (len_zero) begin
              nxt = ST_MF_SYNC; nxt_err = err;
            end else begin
              nxt = ST_DL_SYNC; nxt_err = err; fire_prog = 1'b1;
            end
          end else if (req_kind == RQ_ABORT) begin
            nxt = ST_IDLE; nxt_err = err;
          end else if (is_status) begin
            nxt = cur; nxt_err = err;
          end
        end
        ST_DL_SYNC: begin
          if (is_status) begin
            nxt = done_any ? ST_DL_IDLE : ST_DL_BUSY; nxt_err = err;
          end
        end
        ST_MF_SYNC: begin
          if (is_status) begin
            nxt = ST_MANIFEST; nxt_err = err; fire_manif = 1'b1;
          end
        end
        ST_ERROR: begin
          if (req_kind == RQ_CLEAR) begin nxt = ST_IDLE; nxt_err = ERR_NONE; end
        end
        default: ;
      endcase
    end else if (cur == ST_DL_BUSY && done_any) begin
      nxt = ST_DL_SYNC;
    end else if (cur == ST_MANIFEST && manif_done) begin
      nxt = MANIF_TOLERANT ? ST_IDLE : ST_MF_WAITRST;
    end
  end
endmodule

// File: rtl/fwup_ctrl.sv
module fwup_ctrl #(
  parameter int LEN_W          = 16,
  parameter int MAX_BLOCK      = 2048,
  parameter bit MANIF_TOLERANT = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [2:0]       req_kind,
  input  logic [LEN_W-1:0] req_len,
  input  logic             bus_reset,
  input  logic             prog_done,
  input  logic             prog_err,
  input  logic             manif_done,
  input  logic             manif_err,
  output logic [3:0]       state_code,
  output logic [3:0]       err_code,
  output logic             prog_start,
  output logic             manif_start,
  output logic             reply_valid,
  output logic [3:0]       reply_state,
  output logic [3:0]       reply_err
);
  import fwup_pkg::*;

  fw_state_e  state_q, state_d;
  logic [3:0] err_q, err_d;
  logic       len_zero, len_over, done_any;
  logic       fire_prog, fire_manif, fire_reply;

  fwup_len_check #(.LEN_W(LEN_W), .MAX_BLOCK(MAX_BLOCK)) u_len (
    .len(req_len), .len_zero(len_zero), .len_over(len_over)
  );

  fwup_blk_track u_blk (
    .clk(clk), .rst_n(rst_n), .clr(fire_prog), .prog_done(prog_done), .done_any(done_any)
  );

  fwup_next #(.MANIF_TOLERANT(MANIF_TOLERANT)) u_next (
    .cur(state_q), .err(err_q), .req_valid(req_valid), .req_kind(req_kind),
    .len_zero(len_zero), .len_over(len_over), .bus_reset(bus_reset),
    .done_any(done_any), .prog_err(prog_err), .manif_done(manif_done),
    .manif_err(manif_err), .nxt(state_d), .nxt_err(err_d),
    .fire_prog(fire_prog), .fire_manif(fire_manif), .fire_reply(fire_reply)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_APP_IDLE;
      err_q       <= ERR_NONE;
      prog_start  <= 1'b0;
      manif_start <= 1'b0;
      reply_valid <= 1'b0;
      reply_state <= 4'd0;
      reply_err   <= 4'd0;
    end else begin
      state_q     <= state_d;
      err_q       <= err_d;
      prog_start  <= fire_prog;
      manif_start <= fire_manif;
      reply_valid <= fire_reply;
      if (fire_reply) begin
        reply_state <= state_d;
        reply_err   <= err_d;
      end
    end
  end

  assign state_code = state_q;
  assign err_code   = err_q;
endmodule

// File: rtl/fwup_ctrl_chk.sv
module fwup_ctrl_chk #(
  parameter int LEN_W     = 16,
  parameter int MAX_BLOCK = 2048
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [2:0]       req_kind,
  input logic [LEN_W-1:0] req_len,
  input logic             bus_reset,
  input logic [3:0]       state_code,
  input logic [3:0]       err_code,
  input logic             prog_start,
  input logic             manif_start,
  input logic             reply_valid,
  input logic [3:0]       reply_state,
  input logic [3:0]       reply_err
);
  assert_state_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code <= 4'd8) || (state_code == 4'd10));

  assert_detach_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 4'd0 && req_valid && req_kind == 3'd0 && !bus_reset) |=> (state_code == 4'd1));

  assert_prog_start_sync_R3: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> (state_code == 4'd3));

  assert_manif_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    manif_start |-> (state_code == 4'd7));

  assert_over_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 4'd2 && req_valid && req_kind == 3'd1 && 32'(req_len) > MAX_BLOCK)
      |=> (state_code == 4'd10 && err_code == 4'd1));

  assert_error_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 4'd10) |=> (state_code == 4'd10 || (state_code == 4'd2 && err_code == 4'd0)));

  assert_reply_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reply_valid |-> (reply_state == state_code && reply_err == err_code));
endmodule

bind fwup_ctrl fwup_ctrl_chk #(.LEN_W(LEN_W), .MAX_BLOCK(MAX_BLOCK)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
  .req_len(req_len), .bus_reset(bus_reset), .state_code(state_code),
  .err_code(err_code), .prog_start(prog_start), .manif_start(manif_start),
  .reply_valid(reply_valid), .reply_state(reply_state), .reply_err(reply_err)
);

// File: tb/tb_fwup_ctrl.sv
`timescale 1ns/1ps
module tb_fwup_ctrl;
  localparam int MAXB = 2048;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, bus_reset = 1'b0;
  logic [2:0] req_kind = 3'd0;
  logic [15:0] req_len = 16'd0;
  logic prog_done = 1'b0, prog_err = 1'b0, manif_done = 1'b0, manif_err = 1'b0;
  logic [3:0] state_code, err_code, reply_state, reply_err;
  logic prog_start, manif_start, reply_valid;

  fwup_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_len(req_len), .bus_reset(bus_reset), .prog_done(prog_done),
    .prog_err(prog_err), .manif_done(manif_done), .manif_err(manif_err),
    .state_code(state_code), .err_code(err_code), .prog_start(prog_start),
    .manif_start(manif_start), .reply_valid(reply_valid),
    .reply_state(reply_state), .reply_err(reply_err)
  );

  always #10 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  string tag = "R1";

  // Behavioural reference: integer state, error and flags
  int m_st = 0, m_er = 0, m_rs = 0, m_re = 0;
  bit m_done = 0, m_ps = 0, m_ms = 0, m_rv = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_er = 0; m_done = 0; m_ps = 0; m_ms = 0; m_rv = 0; m_rs = 0; m_re = 0;
    end else begin
      int ns, ne, k, ln;
      bit dn, ps, ms, rv;
      ns = m_st; ne = m_er; ps = 0; ms = 0; rv = 0;
      dn = m_done | prog_done; k = req_kind; ln = req_len;
      if (bus_reset && m_st == 1) ns = 2;
      else if (bus_reset && m_st == 8) ns = 0;
      else if (prog_err && (m_st == 3 || m_st == 4)) begin ns = 10; ne = 3; end
      else if (manif_err && m_st == 7) begin ns = 10; ne = 4; end
      else if (req_valid) begin
        rv = (k == 2);
        if (m_st == 10) begin
          if (k == 3) begin ns = 2; ne = 0; end
        end else if (m_st == 0 && k == 0) ns = 1;
        else if (k == 2 && m_st != 4 && m_st != 7 && m_st != 3 && m_st != 6) ns = m_st;
        else if (k == 2 && m_st == 3) ns = dn ? 5 : 4;
        else if (k == 2 && m_st == 6) begin ns = 7; ms = 1; end
        else if ((m_st == 2 || m_st == 5) && k == 4) ns = 2;
        else if ((m_st == 2 || m_st == 5) && k == 1) begin
          if (ln > MAXB || (ln == 0 && m_st == 2)) begin ns = 10; ne = 1; end
          else if (ln == 0) ns = 6;
          else begin ns = 3; ps = 1; end
        end else begin ns = 10; ne = 2; end
      end else if (m_st == 4 && dn) ns = 3;
      else if (m_st == 7 && manif_done) ns = 8;
      m_done = ps ? 1'b0 : dn;
      m_st = ns; m_er = ne; m_ps = ps; m_ms = ms; m_rv = rv;
      if (rv) begin m_rs = ns; m_re = ne; end
    end
  end

  task automatic chk(input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Compare every signal on every falling edge
  always @(negedge clk) begin
    chk(state_code, m_st, "state_code");
    chk(err_code, m_er, "err_code");
    chk(prog_start, m_ps, "prog_start");
    chk(manif_start, m_ms, "manif_start");
    chk(reply_valid, m_rv, "reply_valid");
    if (m_rv) begin
      chk(reply_state, m_rs, "reply_state");
      chk(reply_err, m_re, "reply_err");
    end
  end

  task automatic req(input int k, input int ln);
    @(posedge clk); #2;
    req_valid = 1; req_kind = 3'(k); req_len = 16'(ln);
    @(posedge clk); #2;
    req_valid = 0;
  endtask

  task automatic pulse(ref logic s);
    @(posedge clk); #2; s = 1;
    @(posedge clk); #2; s = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
  endtask

  task automatic expect_state(input int st);
    @(negedge clk);
    chk(state_code, st, "scenario state");
  endtask

  task automatic enter_dfu();
    req(0, 0); pulse(bus_reset);
  endtask

  initial begin
    tag = "R1"; idle(3); #2 rst_n = 1; idle(2); expect_state(0);
    tag = "R9"; req(2, 0); idle(1);
    tag = "R10"; req(4, 0); expect_state(10);           // abort in app idle is illegal
    tag = "R8"; req(3, 0); expect_state(2);
    #2 rst_n = 0; idle(2); #2 rst_n = 1;
    tag = "R2"; req(0, 0); expect_state(1); pulse(bus_reset); expect_state(2);
    pulse(bus_reset); expect_state(2);                   // ignored in idle
    tag = "R3"; req(1, MAXB); expect_state(3);
    tag = "R2"; pulse(bus_reset); expect_state(3);       // ignored in sync
    tag = "R4"; req(2, 0); expect_state(4); idle(2); pulse(prog_done); idle(1); expect_state(3);
    req(2, 0); expect_state(5);
    tag = "R3"; req(1, 1); expect_state(3);
    tag = "R4"; @(posedge clk); #2 prog_done = 1; req_valid = 1; req_kind = 3'd2;
    @(posedge clk); #2 prog_done = 0; req_valid = 0; expect_state(5);
    tag = "R10"; req(4, 0); expect_state(2);
    tag = "R7"; req(1, MAXB + 1); expect_state(10);
    tag = "R8"; req(1, 10); req(4, 0); req(0, 0); req(2, 0); req(7, 0); expect_state(10);
    req(3, 0); expect_state(2);
    tag = "R7"; req(1, 0); expect_state(10); req(3, 0);
    req(5, 0); expect_state(10); req(3, 0);
    req(1, 16); req(2, 0); req(2, 0); expect_state(10); req(3, 0);
    req(1, 16); pulse(prog_err); expect_state(10); req(3, 0);
    tag = "R11"; req(1, 16); @(posedge clk); #2 prog_err = 1; req_valid = 1; req_kind = 3'd2;
    @(posedge clk); #2 prog_err = 0; req_valid = 0; expect_state(10); req(3, 0);
    tag = "R5"; req(1, 8); pulse(prog_done); req(2, 0); req(1, 0); expect_state(6);
    req(2, 0); expect_state(7);
    tag = "R7"; pulse(manif_err); expect_state(10); req(3, 0);
    tag = "R6"; req(1, 8); pulse(prog_done); req(2, 0); req(1, 0); req(2, 0);
    idle(2); pulse(manif_done); expect_state(8);
    tag = "R9"; req(2, 0); idle(1);
    tag = "R11"; @(posedge clk); #2 bus_reset = 1; req_valid = 1; req_kind = 3'd4;
    @(posedge clk); #2 bus_reset = 0; req_valid = 0; expect_state(0);
    tag = "R7"; req(3, 0); expect_state(10); req(3, 0);
    tag = "R2"; enter_dfu(); req(6, 0); expect_state(10);
    idle(3);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule